// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a chip. It runs the standard sixteen-state test controller from TCK and TMS and holds a 3-bit instruction. It picks the data register that sits between TDI and TDO. Three registers can be picked: a 1-bit bypass stage, a fixed 32-bit identification word, or an external boundary register. The boundary register lives outside this block. The controller feeds it capture, shift and update strobes plus two mode lines, one for driving pins from the chain and one for floating all pins. It takes back the chain's serial output.

Several opcodes share one instruction:
- Two codes select the pin-driving test.
- Two codes select the pin-floating mode.
- The one unassigned code acts as bypass.

The port works only when the scan-select pin is 1 and the test pin is 0. With any other pin pattern the port is held in reset with its output disabled. The asynchronous reset input is the system reset.

Top module: `tap_ctrl`

## Requirements
- R1: When `scan_sel` is not 1 or `test_mode` is not 0, the controller is held in reset. In that condition `tdo_oe` is 0, both mode outputs are 0, and a TMS/TDI sequence changes nothing. Once the pattern is enabled again, the identification register is selected.
- R2: Driving `trst_n` low at once forces the Test-Logic-Reset state and the identification instruction, and turns off `tdo_oe` and both mode outputs.
- R3: Five TCK cycles with TMS high reach Test-Logic-Reset from any state, and the instruction becomes identification.
- R4: In Capture-IR the instruction shift stage loads 001. Shift-IR moves it out least significant bit first, so TDO shows 1, 0, 0.
- R5: Opcodes 111 and 101 select bypass. Both mode outputs are 0.
- R6: Opcode 010 selects identification. A DR scan shifts out 32'h05B1003F least significant bit first, followed by the TDI bits delayed by 32 cycles.
- R7: Opcodes 000 and 011 select the boundary register and raise `mode_extest`. TDO follows `bsr_so`.
- R8: Opcode 001 selects the boundary register with both mode outputs at 0.
- R9: Opcodes 100 and 110 select the bypass stage and raise `mode_highz`. `mode_extest` and `mode_highz` are never 1 together.
- R10: The bypass stage loads 0 in Capture-DR. In Shift-DR, TDO then repeats TDI delayed by one cycle.
- R11: TDO and `tdo_oe` change only on the falling edge of TCK. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R12: `bs_capture`, `bs_shift` and `bs_update` pulse in Capture-DR, Shift-DR and Update-DR, and only when the boundary register is selected. At most one of them is high at a time.
- R13: The instruction changes only on the falling edge of TCK while in Update-IR or Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tms | input | 1 | Test mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| trst_n | input | 1 | Asynchronous active-low reset, shared with system reset |
| scan_sel | input | 1 | Compliance select pin, must be 1 for operation |
| test_mode | input | 1 | Compliance test pin, must be 0 for operation |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| bs_capture | output | 1 | Boundary register capture strobe |
| bs_shift | output | 1 | Boundary register shift strobe |
| bs_update | output | 1 | Boundary register update strobe |
| mode_extest | output | 1 | Boundary cells drive the pins |
| mode_highz | output | 1 | All pin drivers float |

## Verification
A shifted bit appears on TDO at the falling edge that follows the rising edge entering the shift state. The bench therefore drives TMS, TDI and `bsr_so` a quarter period after each falling edge, and reads TDO in that same window. Each read shows the bit that the next rising edge shifts.

A new instruction takes effect at the falling edge spent in Update-IR. The mode outputs are read only after that edge.

The boundary strobes are decoded from the registered state. The bench counts them at falling edges, where they are settled, and compares the totals with one capture, one update and one shift per scanned bit.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 3;

    typedef enum logic [3:0] {
        ST_RESET, ST_IDLE,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        INS_BYPASS, INS_IDCODE, INS_SAMPLE, INS_EXTEST, INS_HIGHZ
    } instr_e;

    typedef enum logic [1:0] {
        PATH_BYP, PATH_ID, PATH_BSR
    } path_e;

    // Opcode map; the unassigned code falls back to bypass.
    function automatic instr_e decode_op(input logic [IR_W-1:0] op);
        instr_e r;
        case (op)
            3'b010:          r = INS_IDCODE;
            3'b001:          r = INS_SAMPLE;
            3'b000, 3'b011:  r = INS_EXTEST;
            3'b100, 3'b110:  r = INS_HIGHZ;
            default:         r = INS_BYPASS;
        endcase
        return r;
    endfunction

    function automatic path_e path_of(input instr_e ins);
        path_e r;
        case (ins)
            INS_IDCODE:             r = PATH_ID;
            INS_SAMPLE, INS_EXTEST: r = PATH_BSR;
            default:                r = PATH_BYP;
        endcase
        return r;
    endfunction

    function automatic tap_state_e next_state(input tap_state_e s, input logic m);
        tap_state_e r;
        case (s)
            ST_RESET:  r = m ? ST_RESET  : ST_IDLE;
            ST_IDLE:   r = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: r = m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r = m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r = m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r = m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: r = m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: r = m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r = m ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: r = m ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: r = m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r = m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r = m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: r = m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: r = m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: r = m ? ST_SEL_DR : ST_IDLE;
            default:   r = ST_RESET;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       rst_n,
    input  logic       tms,
    output tap_state_e state_q
);
    tap_state_e state_d;

    always_comb begin
        state_d = next_state(state_q, tms);
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
#(
    parameter logic [IR_W-1:0] IR_CAPTURE = 3'b001
) (
    input  logic            tck,
    input  logic            rst_n,
    input  tap_state_e      state,
    input  logic            tdi,
    output logic [IR_W-1:0] sh_q,
    output instr_e          instr_q
);
    logic [IR_W-1:0] sh_d;
    instr_e          instr_d;

    // Shift stage: rising edge
    always_comb begin
        sh_d = sh_q;
        if (state == ST_CAP_IR)     sh_d = IR_CAPTURE;
        else if (state == ST_SH_IR) sh_d = {tdi, sh_q[IR_W-1:1]};
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) sh_q <= IR_CAPTURE;
        else        sh_q <= sh_d;
    end

    // Held instruction: falling edge
    always_comb begin
        instr_d = instr_q;
        if (state == ST_RESET)       instr_d = INS_IDCODE;
        else if (state == ST_UPD_IR) instr_d = decode_op(sh_q);
    end

    always_ff @(negedge tck or negedge rst_n) begin
        if (!rst_n) instr_q <= INS_IDCODE;
        else        instr_q <= instr_d;
    end
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h05B1003F
) (
    input  logic       tck,
    input  logic       rst_n,
    input  tap_state_e state,
    input  path_e      path,
    input  logic       tdi,
    output logic       byp_q,
    output logic       id_so
);
    typedef struct packed {
        logic            byp;
        logic [ID_W-1:0] id;
    } dr_t;

    dr_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (state == ST_CAP_DR) begin
            if (path == PATH_BYP) r_d.byp = 1'b0;
            if (path == PATH_ID)  r_d.id  = ID_VALUE;
        end else if (state == ST_SH_DR) begin
            if (path == PATH_BYP) r_d.byp = tdi;
            if (path == PATH_ID)  r_d.id  = {tdi, r_q.id[ID_W-1:1]};
        end
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) r_q <= '{byp: 1'b0, id: ID_VALUE};
        else        r_q <= r_d;
    end

    assign byp_q = r_q.byp;
    assign id_so = r_q.id[0];
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
    import tap_pkg::*;
#(
    parameter int              ID_W       = 32,
    parameter logic [ID_W-1:0] ID_VALUE   = 32'h05B1003F,
    parameter logic [IR_W-1:0] IR_CAPTURE = 3'b001
) (
    input  logic tck,
    input  logic tms,
    input  logic tdi,
    input  logic trst_n,
    input  logic scan_sel,
    input  logic test_mode,
    input  logic bsr_so,
    output logic tdo,
    output logic tdo_oe,
    output logic bs_capture,
    output logic bs_shift,
    output logic bs_update,
    output logic mode_extest,
    output logic mode_highz
);
    typedef struct packed {
        logic dat;
        logic oe;
    } out_t;

    logic            rst_eff_n;
    tap_state_e      st_q;
    instr_e          instr_q;
    path_e           path;
    logic [IR_W-1:0] ir_sh_q;
    logic            byp_q;
    logic            id_so;
    out_t            out_d, out_q;

    // Compliance pattern gates the reset
    assign rst_eff_n = trst_n & scan_sel & ~test_mode;

    tap_fsm u_fsm (
        .tck     (tck),
        .rst_n   (rst_eff_n),
        .tms     (tms),
        .state_q (st_q)
    );

    tap_ir #(.IR_CAPTURE(IR_CAPTURE)) u_ir (
        .tck     (tck),
        .rst_n   (rst_eff_n),
        .state   (st_q),
        .tdi     (tdi),
        .sh_q    (ir_sh_q),
        .instr_q (instr_q)
    );

    assign path = path_of(instr_q);

    tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck   (tck),
        .rst_n (rst_eff_n),
        .state (st_q),
        .path  (path),
        .tdi   (tdi),
        .byp_q (byp_q),
        .id_so (id_so)
    );

    always_comb begin
        out_d.oe = (st_q == ST_SH_IR) || (st_q == ST_SH_DR);
        if (st_q == ST_SH_IR) begin
            out_d.dat = ir_sh_q[0];
        end else begin
            case (path)
                PATH_ID:  out_d.dat = id_so;
                PATH_BSR: out_d.dat = bsr_so;
                default:  out_d.dat = byp_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge rst_eff_n) begin
        if (!rst_eff_n) out_q <= '{dat: 1'b0, oe: 1'b0};
        else            out_q <= out_d;
    end

    assign tdo         = out_q.dat;
    assign tdo_oe      = out_q.oe;
    assign bs_capture  = (path == PATH_BSR) && (st_q == ST_CAP_DR);
    assign bs_shift    = (path == PATH_BSR) && (st_q == ST_SH_DR);
    assign bs_update   = (path == PATH_BSR) && (st_q == ST_UPD_DR);
    assign mode_extest = (instr_q == INS_EXTEST);
    assign mode_highz  = (instr_q == INS_HIGHZ);
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk
    import tap_pkg::*;
(
    input logic            tck,
    input logic            rst_n,
    input tap_state_e      st,
    input instr_e          instr,
    input logic [IR_W-1:0] ir_sh,
    input logic            byp,
    input logic            tdo_oe,
    input logic            bs_capture,
    input logic            bs_shift,
    input logic            bs_update,
    input logic            mode_extest,
    input logic            mode_highz
);
    // R11
    oe_only_shift_chk: assert property (@(posedge tck) disable iff (!rst_n)
        tdo_oe |-> (st == ST_SH_DR || st == ST_SH_IR));

    // R4
    ir_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (st == ST_CAP_IR) |=> (ir_sh == 3'b001));

    // R10
    byp_capture_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (st == ST_CAP_DR && (instr == INS_BYPASS || instr == INS_HIGHZ)) |=> !byp);

    // R12
    strobe_onehot_chk: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0({bs_capture, bs_shift, bs_update}));

    // R12
    strobe_path_chk: assert property (@(posedge tck) disable iff (!rst_n)
        (bs_capture || bs_shift || bs_update) |-> (instr == INS_EXTEST || instr == INS_SAMPLE));

    // R9
    mode_excl_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !(mode_extest && mode_highz));

    // R13
    instr_hold_chk: assert property (@(posedge tck) disable iff (!rst_n)
        !$stable(instr) |-> (st == ST_UPD_IR || st == ST_RESET));
endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
    .tck         (tck),
    .rst_n       (rst_eff_n),
    .st          (st_q),
    .instr       (instr_q),
    .ir_sh       (ir_sh_q),
    .byp         (byp_q),
    .tdo_oe      (tdo_oe),
    .bs_capture  (bs_capture),
    .bs_shift    (bs_shift),
    .bs_update   (bs_update),
    .mode_extest (mode_extest),
    .mode_highz  (mode_highz)
);

// File: tb/tap_ctrl_test.sv
module tap_ctrl_test;
    localparam int TCK_PERIOD = 100;
    localparam logic [31:0] ID_EXP = 32'h05B1003F;

    logic tck = 1'b0;
    logic tms = 1'b1, tdi = 1'b0, trst_n = 1'b0;
    logic scan_sel = 1'b1, test_mode = 1'b0, bsr_so = 1'b0;
    logic tdo, tdo_oe, bs_capture, bs_shift, bs_update, mode_extest, mode_highz;

    int n_vec = 0, n_err = 0;
    int cnt_cap = 0, cnt_sh = 0, cnt_upd = 0;
    logic s_tdo, s_oe;

    tap_ctrl uut (
        .tck(tck), .tms(tms), .tdi(tdi), .trst_n(trst_n),
        .scan_sel(scan_sel), .test_mode(test_mode), .bsr_so(bsr_so),
        .tdo(tdo), .tdo_oe(tdo_oe), .bs_capture(bs_capture), .bs_shift(bs_shift),
        .bs_update(bs_update), .mode_extest(mode_extest), .mode_highz(mode_highz)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    always @(negedge tck) begin
        cnt_cap = cnt_cap + int'(bs_capture);
        cnt_sh  = cnt_sh  + int'(bs_shift);
        cnt_upd = cnt_upd + int'(bs_update);
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic m, input logic d, input logic b);
        @(negedge tck);
        #(TCK_PERIOD/4);
        s_tdo = tdo; s_oe = tdo_oe;
        tms = m; tdi = d; bsr_so = b;
        @(posedge tck);
    endtask

    task automatic to_idle();
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
    endtask

    task automatic scan_ir(input logic [2:0] op, output logic [2:0] got);
        step(1, 0, 0); step(1, 0, 0); step(0, 0, 0); step(0, 0, 0);
        for (int i = 0; i < 3; i++) begin
            step(i == 2, op[i], 1'b0);
            got[i] = s_tdo;
        end
        step(1, 0, 0); step(0, 0, 0);
    endtask

    task automatic scan_dr(input int len, input logic [63:0] din, input logic [64:0] bsr,
                           output logic [63:0] got, output logic oe_ok);
        got = '0; oe_ok = 1'b1;
        step(1, 0, 0); step(0, 0, 0); step(0, 0, bsr[0]);
        for (int i = 0; i < len; i++) begin
            step(i == len - 1, din[i], bsr[i+1]);
            got[i] = s_tdo;
            oe_ok &= s_oe;
        end
        step(1, 0, 0);
        step(0, 0, 0);
        oe_ok &= !s_oe;
    endtask

    function automatic int path_of(input logic [2:0] op);
        case (op)
            3'b111, 3'b101, 3'b100, 3'b110: return 0;
            3'b010:                         return 1;
            default:                        return 2;
        endcase
    endfunction

    function automatic logic [63:0] exp_dr(input int p, input int len,
                                           input logic [63:0] din, input logic [64:0] bsr);
        logic [63:0] r = '0;
        for (int i = 0; i < len; i++) begin
            case (p)
                0:       r[i] = (i == 0) ? 1'b0 : din[i-1];
                1:       r[i] = (i < 32) ? ID_EXP[i] : din[i-32];
                default: r[i] = bsr[i];
            endcase
        end
        return r;
    endfunction

    task automatic dr_check(input string req, input logic [2:0] op, input int len);
        logic [63:0] din, got;
        logic [64:0] bsr;
        logic oe_ok;
        int p;
        din = {$urandom, $urandom};
        bsr = {1'b0, $urandom, $urandom};
        p = path_of(op);
        cnt_cap = 0; cnt_sh = 0; cnt_upd = 0;
        scan_dr(len, din, bsr, got, oe_ok);
        chk(req, got, exp_dr(p, len, din, bsr));
        // R11
        chk({req, " R11 oe"}, 64'(oe_ok), 64'd1);
        // R12
        chk({req, " R12 strobes"}, {cnt_cap[15:0], cnt_sh[15:0], cnt_upd[15:0]},
            (p == 2) ? {16'd1, 16'(len), 16'd1} : 64'd0);
    endtask

    task automatic load(input logic [2:0] op);
        logic [2:0] g;
        scan_ir(op, g);
        // R4
        chk("R4 capture", 64'(g), 64'd1);
        // R7 R9
        chk("R7 R9 modes", {mode_extest, mode_highz},
            {(op == 3'b000 || op == 3'b011), (op == 3'b100 || op == 3'b110)});
    endtask

    initial begin
        #(TCK_PERIOD * 150000);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        #(TCK_PERIOD * 2);
        // R2 reset state
        chk("R2 reset", {tdo_oe, mode_extest, mode_highz}, 3'b000);
        trst_n = 1'b1;
        to_idle();
        dr_check("R6 idcode default", 3'b010, 40);

        // directed opcodes
        load(3'b111); dr_check("R5 bypass 111", 3'b111, 20);
        load(3'b101); dr_check("R5 bypass 101", 3'b101, 12);
        load(3'b010); dr_check("R6 idcode", 3'b010, 48);
        load(3'b000); dr_check("R7 extest 000", 3'b000, 16);
        load(3'b011); dr_check("R7 extest 011", 3'b011, 9);
        load(3'b001); dr_check("R8 sample", 3'b001, 10);
        load(3'b100); dr_check("R9 highz 100", 3'b100, 7);
        load(3'b110); dr_check("R9 highz 110", 3'b110, 1);
        load(3'b111); dr_check("R10 bypass one bit", 3'b111, 1);

        // R3 TMS reset
        load(3'b011);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0);
        chk("R3 tms reset modes", {mode_extest, mode_highz}, 2'b00);
        step(1'b0, 1'b0, 1'b0);
        dr_check("R3 idcode after tms reset", 3'b010, 32);

        // R2 asynchronous reset mid-operation
        load(3'b100);
        #(TCK_PERIOD/8);
        trst_n = 1'b0;
        #1;
        chk("R2 async reset", {tdo_oe, mode_extest, mode_highz}, 3'b000);
        #(TCK_PERIOD);
        trst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0);
        dr_check("R2 idcode after reset", 3'b010, 32);

        // R1 compliance gating via select pin and via test pin
        for (int k = 0; k < 2; k++) begin
            logic [63:0] g;
            logic ok;
            load(3'b000);
            if (k == 0) scan_sel = 1'b0; else test_mode = 1'b1;
            #1;
            chk("R1 gated modes", {tdo_oe, mode_extest, mode_highz}, 3'b000);
            scan_dr(8, 64'hA5, 65'h0, g, ok);
            chk("R1 gated oe", 64'(ok), 64'd0);
            chk("R1 gated tdo", g, 64'd0);
            scan_sel = 1'b1; test_mode = 1'b0;
            step(1'b0, 1'b0, 1'b0);
            dr_check("R1 idcode after enable", 3'b010, 32);
        end

        // random opcodes and lengths
        for (int n = 0; n < 40; n++) begin
            logic [2:0] op;
            int len;
            op  = 3'($urandom);
            len = 1 + int'($urandom % 60);
            load(op);
            dr_check("R5-R10 random", op, len);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end
endmodule